// File: doc/BRIEF.md
# Time-Multiplexed Quadratic Spiking Neuron Updater

This block advances a population of virtual spiking neurons by one discrete time step each time it is started. A single arithmetic datapath is shared by every neuron slot. For each slot, local storage holds a membrane potential, a recovery variable and a kind flag that marks the neuron as excitatory or inhibitory. During a step the block visits every slot once. It fetches the slot's state, samples that slot's summed input current from the surrounding logic, and evaluates a quadratic membrane map and a linear recovery relaxation in signed Q16.16 fixed point. It then writes the new state back. When a slot's stored potential has reached the firing threshold, the block emits a spike event tagged with the slot index, and it applies the kind-specific reset in place of the map.

All products come from one iterative shift-add multiplier that resolves one multiplier bit per cycle, so the block uses no hardware multiplier. Division by the relaxation time constant is replaced by multiplication with a stored reciprocal. Per-kind constants (reset potential, recovery kick, recovery slope and reciprocal time constant) and the per-slot state are written through a small configuration port while the block is idle. The shared map coefficients and the firing threshold are build-time parameters.

The controller is a state machine with seven states. ST_IDLE waits for start. ST_READ issues the slot read. ST_EVAL compares the fetched potential with the threshold and either fires or begins the arithmetic. ST_ISSUE launches one product. ST_MUL waits for that product. ST_COMMIT writes the sub-threshold result. ST_DONE signals the end of the step. The transitions are:
- ST_IDLE→ST_READ on start.
- ST_READ→ST_EVAL always.
- ST_EVAL→ST_ISSUE when the slot does not fire.
- ST_EVAL→ST_READ when the slot fires and is not the last slot.
- ST_EVAL→ST_DONE when the slot fires and is the last slot.
- ST_ISSUE→ST_MUL always.
- ST_MUL→ST_ISSUE when a product finishes and more products remain.
- ST_MUL→ST_COMMIT when the fifth product finishes.
- ST_COMMIT→ST_READ when the slot is not the last slot.
- ST_COMMIT→ST_DONE when the slot is the last slot.
- ST_DONE→ST_IDLE always.

Top module: `izh_neuron_updater`

## Requirements
- R1: After reset, spike_valid and step_done are low and cur_idx is 0. The per-kind constants hold these Q16.16 defaults. Kind 0 (excitatory): reset potential −65.0, kick 10.0, slope 0.24 (raw 15729), reciprocal 1/43 (raw 1524). Kind 1 (inhibitory): reset potential −65.0, kick 1.0, slope 0.25 (raw 16384), reciprocal 1/100 (raw 655).
- R2: A start pulse seen in ST_IDLE begins a step that visits slots 0 to N_SLOTS−1 in ascending order. While a slot is processed, cur_idx equals its index, and cur_in is sampled in the cycle after its read is issued.
- R3: A slot whose stored potential is at or above V_THRESH (30.0, raw 0x001E0000) fires. In that cycle spike_valid is high for one cycle and spike_idx carries the slot index. The potential becomes the kind's reset potential, and the recovery variable becomes sat(U + kick).
- R4: Let mq(x,y) = sat(floor(x·y / 2^16)). For a non-firing slot, the next potential is sat(mq(A, mq(V,V)) + mq(B1,V) + C − U + I), with A = 0.04 (raw 2621), B1 = 6.0 (raw 393216) and C = 140.0 (raw 9175040).
- R5: For a non-firing slot, the next recovery value is sat(U + mq(sat(mq(slope,V) − U), recip)). It uses the old V and U and the slot's own kind constants.
- R6: sat() clamps to the signed 32-bit range [−2^31, 2^31−1]. This applies to every product and every sum named in R3 to R5.
- R7: step_done is a one-cycle pulse after the last slot. A start pulse while a step runs is ignored, and no further step begins until start is pulsed in ST_IDLE.
- R8: Configuration writes take effect only in ST_IDLE. cfg_op selects the write: 0 writes a kind constant, 1 writes slot V, 2 writes slot U, 3 writes the slot kind. For op 0, cfg_addr[1:0] picks the constant (0 reset potential, 1 kick, 2 slope, 3 reciprocal), cfg_addr[2] picks the kind, and higher address bits must be zero. For op 3, nonzero data marks the slot inhibitory (kind 1).
- R9: Each slot uses the constant set of its own stored kind, both for firing and for sub-threshold updates.
- R10: Within a step, spike events come out in strictly ascending index order, at most one per slot, and never in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins one step when idle |
| cur_idx | output | IDX_W | Slot whose input current is requested |
| cur_in | input | DATA_W | Summed input current for cur_idx, Q16.16 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | Configuration operation select |
| cfg_addr | input | IDX_W | Slot index or kind/constant select |
| cfg_data | input | DATA_W | Configuration write data |
| spike_valid | output | 1 | Spike event valid |
| spike_idx | output | IDX_W | Index of the firing slot |
| step_done | output | 1 | One-cycle end-of-step pulse |

## Verification
The bench builds the block with N_SLOTS = 8 and DATA_W = 32, which gives a 3-bit index and about 1400 cycles per step. At that size, dozens of full steps fit in the run, so the last-slot transition into ST_DONE, multi-step membrane trajectories and the effect of a kick on later steps all come within reach. A reference model built from the fixed-point formulas predicts each step's spike list. Stimuli place potentials exactly on the threshold and one LSB below it, and they drive the squared-potential, current and recovery terms into saturation. Configuration and start pulses are issued in the middle of a step to show they have no effect.

// File: rtl/izh_pkg.sv
package izh_pkg;

    localparam int NUM_KINDS = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_EVAL,
        ST_ISSUE,
        ST_MUL,
        ST_COMMIT,
        ST_DONE
    } upd_state_e;

    typedef enum logic [1:0] {
        CFG_KIND_CONST = 2'd0,
        CFG_SLOT_V     = 2'd1,
        CFG_SLOT_U     = 2'd2,
        CFG_SLOT_KIND  = 2'd3
    } cfg_op_e;

    typedef enum logic [1:0] {
        KF_VRESET = 2'd0,
        KF_KICK   = 2'd1,
        KF_SLOPE  = 2'd2,
        KF_RECIP  = 2'd3
    } kind_field_e;

    typedef enum logic [2:0] {
        OP_SQUARE = 3'd0,
        OP_QUAD   = 3'd1,
        OP_LIN    = 3'd2,
        OP_SLOPE  = 3'd3,
        OP_RELAX  = 3'd4
    } mul_op_e;

endpackage

// File: rtl/izh_shiftadd_mul.sv
module izh_shiftadd_mul #(
    parameter int DATA_W = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic signed [DATA_W-1:0]   op_a,
    input  logic signed [DATA_W-1:0]   op_b,
    output logic                       busy,
    output logic                       done,
    output logic signed [2*DATA_W-1:0] prod
);
    localparam int PROD_W = 2 * DATA_W;
    localparam int CNT_W  = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    logic signed [PROD_W-1:0] acc;
    logic signed [PROD_W-1:0] mcand;
    logic        [DATA_W-1:0] mplier;
    logic        [CNT_W-1:0]  cnt;

    // One multiplier bit per cycle; the top bit carries negative weight.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
            cnt    <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                acc    <= '0;
                mcand  <= {{(PROD_W-DATA_W){op_a[DATA_W-1]}}, op_a};
                mplier <= op_b;
                cnt    <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                if (mplier[0]) begin
                    if (cnt == LAST_BIT) acc <= acc - mcand;
                    else                 acc <= acc + mcand;
                end
                mcand  <= mcand <<< 1;
                mplier <= mplier >> 1;
                cnt    <= cnt + 1'b1;
                if (cnt == LAST_BIT) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign prod = acc;

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/izh_kind_params.sv
module izh_kind_params
    import izh_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter logic signed [DATA_W-1:0] EXC_VRESET = -32'sd4259840,
    parameter logic signed [DATA_W-1:0] EXC_KICK   = 32'sd655360,
    parameter logic signed [DATA_W-1:0] EXC_SLOPE  = 32'sd15729,
    parameter logic signed [DATA_W-1:0] EXC_RECIP  = 32'sd1524,
    parameter logic signed [DATA_W-1:0] INH_VRESET = -32'sd4259840,
    parameter logic signed [DATA_W-1:0] INH_KICK   = 32'sd65536,
    parameter logic signed [DATA_W-1:0] INH_SLOPE  = 32'sd16384,
    parameter logic signed [DATA_W-1:0] INH_RECIP  = 32'sd655
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic                     wr_kind,
    input  kind_field_e              wr_field,
    input  logic signed [DATA_W-1:0] wr_data,
    input  logic                     rd_kind,
    output logic signed [DATA_W-1:0] rd_vreset,
    output logic signed [DATA_W-1:0] rd_kick,
    output logic signed [DATA_W-1:0] rd_slope,
    output logic signed [DATA_W-1:0] rd_recip
);
    logic signed [DATA_W-1:0] vreset_a [NUM_KINDS];
    logic signed [DATA_W-1:0] kick_a   [NUM_KINDS];
    logic signed [DATA_W-1:0] slope_a  [NUM_KINDS];
    logic signed [DATA_W-1:0] recip_a  [NUM_KINDS];

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        localparam logic signed [DATA_W-1:0] RV = (k == 0) ? EXC_VRESET : INH_VRESET;
        localparam logic signed [DATA_W-1:0] RK = (k == 0) ? EXC_KICK   : INH_KICK;
        localparam logic signed [DATA_W-1:0] RS = (k == 0) ? EXC_SLOPE  : INH_SLOPE;
        localparam logic signed [DATA_W-1:0] RR = (k == 0) ? EXC_RECIP  : INH_RECIP;

        logic signed [DATA_W-1:0] vreset_q, kick_q, slope_q, recip_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vreset_q <= RV;
                kick_q   <= RK;
                slope_q  <= RS;
                recip_q  <= RR;
            end else if (wr_en && (wr_kind == 1'(k))) begin
                unique case (wr_field)
                    KF_VRESET: vreset_q <= wr_data;
                    KF_KICK:   kick_q   <= wr_data;
                    KF_SLOPE:  slope_q  <= wr_data;
                    KF_RECIP:  recip_q  <= wr_data;
                    default:   ;
                endcase
            end
        end

        assign vreset_a[k] = vreset_q;
        assign kick_a[k]   = kick_q;
        assign slope_a[k]  = slope_q;
        assign recip_a[k]  = recip_q;
    end

    assign rd_vreset = vreset_a[rd_kind];
    assign rd_kick   = kick_a[rd_kind];
    assign rd_slope  = slope_a[rd_kind];
    assign rd_recip  = recip_a[rd_kind];

endmodule

// File: rtl/izh_slot_store.sv
module izh_slot_store #(
    parameter int N_SLOTS = 1000,
    parameter int DATA_W  = 32,
    parameter int IDX_W   = 10
) (
    input  logic                     clk,
    input  logic                     we_v,
    input  logic                     we_u,
    input  logic                     we_k,
    input  logic [IDX_W-1:0]         waddr,
    input  logic signed [DATA_W-1:0] wv,
    input  logic signed [DATA_W-1:0] wu,
    input  logic                     wk,
    input  logic [IDX_W-1:0]         raddr,
    output logic signed [DATA_W-1:0] rv,
    output logic signed [DATA_W-1:0] ru,
    output logic                     rk
);
    logic signed [DATA_W-1:0] v_mem [N_SLOTS];
    logic signed [DATA_W-1:0] u_mem [N_SLOTS];
    logic                     k_mem [N_SLOTS];

    // Registered read: data for raddr appears one cycle later.
    always_ff @(posedge clk) begin
        if (we_v) v_mem[waddr] <= wv;
        if (we_u) u_mem[waddr] <= wu;
        if (we_k) k_mem[waddr] <= wk;
        rv <= v_mem[raddr];
        ru <= u_mem[raddr];
        rk <= k_mem[raddr];
    end

endmodule

// File: rtl/izh_neuron_updater.sv
module izh_neuron_updater
    import izh_pkg::*;
#(
    parameter int N_SLOTS = 1000,
    parameter int DATA_W  = 32,
    parameter int FRAC_W  = 16,
    parameter logic signed [DATA_W-1:0] COEF_A   = 32'sd2621,
    parameter logic signed [DATA_W-1:0] COEF_B1  = 32'sd393216,
    parameter logic signed [DATA_W-1:0] COEF_C   = 32'sd9175040,
    parameter logic signed [DATA_W-1:0] V_THRESH = 32'sd1966080,
    parameter int IDX_W = (N_SLOTS > 8) ? $clog2(N_SLOTS) : 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    output logic [IDX_W-1:0]         cur_idx,
    input  logic signed [DATA_W-1:0] cur_in,
    input  logic                     cfg_we,
    input  logic [1:0]               cfg_op,
    input  logic [IDX_W-1:0]         cfg_addr,
    input  logic signed [DATA_W-1:0] cfg_data,
    output logic                     spike_valid,
    output logic [IDX_W-1:0]         spike_idx,
    output logic                     step_done
);
    localparam int WIDE_W = 2 * DATA_W;
    localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(N_SLOTS - 1);
    localparam logic signed [WIDE_W-1:0] SAT_MAX = {{(DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] SAT_MIN = {{(DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

    function automatic logic signed [WIDE_W-1:0] ext(input logic signed [DATA_W-1:0] x);
        return {{(WIDE_W-DATA_W){x[DATA_W-1]}}, x};
    endfunction

    function automatic logic signed [DATA_W-1:0] sat_w(input logic signed [WIDE_W-1:0] x);
        if (x > SAT_MAX)      return SAT_MAX[DATA_W-1:0];
        else if (x < SAT_MIN) return SAT_MIN[DATA_W-1:0];
        else                  return x[DATA_W-1:0];
    endfunction

    upd_state_e state, state_nx;

    logic [IDX_W-1:0]         slot;
    mul_op_e                  op_r;
    logic signed [DATA_W-1:0] v_r, u_r, i_r;
    logic                     kind_r;
    logic signed [DATA_W-1:0] sq_r, quad_r, lin_r, kv_r, relax_r;

    logic signed [DATA_W-1:0] rd_v, rd_u;
    logic                     rd_k;
    logic                     st_we_v, st_we_u, st_we_k, st_wk;
    logic [IDX_W-1:0]         st_waddr;
    logic signed [DATA_W-1:0] st_wv, st_wu;

    logic                     kp_wr, kp_sel;
    logic signed [DATA_W-1:0] kp_vreset, kp_kick, kp_slope, kp_recip;

    logic                       mul_start, mul_busy, mul_done;
    logic signed [DATA_W-1:0]   mul_a, mul_b, qres;
    logic signed [2*DATA_W-1:0] mul_prod;

    logic                     fire, last_slot, cfg_idle, cfg_slot_ok;
    logic signed [DATA_W-1:0] v_next, u_next, diff_ku;

    assign fire        = (state == ST_EVAL) && (rd_v >= V_THRESH);
    assign last_slot   = (slot == LAST_SLOT);
    assign cfg_idle    = (state == ST_IDLE) && cfg_we;
    assign cfg_slot_ok = (cfg_addr <= LAST_SLOT);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_READ;
            ST_READ:   state_nx = ST_EVAL;
            ST_EVAL:   begin
                if (!fire)          state_nx = ST_ISSUE;
                else if (last_slot) state_nx = ST_DONE;
                else                state_nx = ST_READ;
            end
            ST_ISSUE:  state_nx = ST_MUL;
            ST_MUL:    begin
                if (mul_done) state_nx = (op_r == OP_RELAX) ? ST_COMMIT : ST_ISSUE;
            end
            ST_COMMIT: state_nx = last_slot ? ST_DONE : ST_READ;
            ST_DONE:   state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        spike_valid = fire;
        spike_idx   = slot;
        step_done   = (state == ST_DONE);
        mul_start   = (state == ST_ISSUE);
        cur_idx     = slot;
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot    <= '0;
            op_r    <= OP_SQUARE;
            v_r     <= '0;
            u_r     <= '0;
            i_r     <= '0;
            kind_r  <= 1'b0;
            sq_r    <= '0;
            quad_r  <= '0;
            lin_r   <= '0;
            kv_r    <= '0;
            relax_r <= '0;
        end else begin
            if (state == ST_IDLE && start) slot <= '0;
            if (state == ST_EVAL) begin
                v_r    <= rd_v;
                u_r    <= rd_u;
                kind_r <= rd_k;
                i_r    <= cur_in;
                op_r   <= OP_SQUARE;
                if (fire && !last_slot) slot <= slot + 1'b1;
            end
            if (state == ST_MUL && mul_done) begin
                unique case (op_r)
                    OP_SQUARE: sq_r    <= qres;
                    OP_QUAD:   quad_r  <= qres;
                    OP_LIN:    lin_r   <= qres;
                    OP_SLOPE:  kv_r    <= qres;
                    OP_RELAX:  relax_r <= qres;
                    default:   ;
                endcase
                op_r <= mul_op_e'(op_r + 3'd1);
            end
            if (state == ST_COMMIT && !last_slot) slot <= slot + 1'b1;
        end
    end

    // ---------------- arithmetic ----------------
    assign diff_ku = sat_w(ext(kv_r) - ext(u_r));
    assign qres    = sat_w(mul_prod >>> FRAC_W);
    assign v_next  = sat_w(ext(quad_r) + ext(lin_r) + ext(COEF_C) - ext(u_r) + ext(i_r));
    assign u_next  = sat_w(ext(u_r) + ext(relax_r));

    always_comb begin
        mul_a = v_r;
        mul_b = v_r;
        unique case (op_r)
            OP_SQUARE: begin mul_a = v_r;     mul_b = v_r;      end
            OP_QUAD:   begin mul_a = COEF_A;  mul_b = sq_r;     end
            OP_LIN:    begin mul_a = COEF_B1; mul_b = v_r;      end
            OP_SLOPE:  begin mul_a = kp_slope; mul_b = v_r;     end
            OP_RELAX:  begin mul_a = diff_ku; mul_b = kp_recip; end
            default:   ;
        endcase
    end

    // ---------------- store write arbitration ----------------
    always_comb begin
        st_we_v  = 1'b0;
        st_we_u  = 1'b0;
        st_we_k  = 1'b0;
        st_waddr = slot;
        st_wv    = v_next;
        st_wu    = u_next;
        st_wk    = 1'b0;
        if (fire) begin
            st_we_v = 1'b1;
            st_we_u = 1'b1;
            st_wv   = kp_vreset;
            st_wu   = sat_w(ext(rd_u) + ext(kp_kick));
        end else if (state == ST_COMMIT) begin
            st_we_v = 1'b1;
            st_we_u = 1'b1;
        end else if (cfg_idle && cfg_slot_ok) begin
            st_waddr = cfg_addr;
            st_wv    = cfg_data;
            st_wu    = cfg_data;
            st_wk    = (cfg_data != '0);
            st_we_v  = (cfg_op == CFG_SLOT_V);
            st_we_u  = (cfg_op == CFG_SLOT_U);
            st_we_k  = (cfg_op == CFG_SLOT_KIND);
        end
    end

    assign kp_wr  = cfg_idle && (cfg_op == CFG_KIND_CONST) && ((cfg_addr >> 3) == '0);
    assign kp_sel = (state == ST_EVAL) ? rd_k : kind_r;

    // ---------------- sub-blocks ----------------
    izh_slot_store #(
        .N_SLOTS (N_SLOTS),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_store (
        .clk   (clk),
        .we_v  (st_we_v),
        .we_u  (st_we_u),
        .we_k  (st_we_k),
        .waddr (st_waddr),
        .wv    (st_wv),
        .wu    (st_wu),
        .wk    (st_wk),
        .raddr (slot),
        .rv    (rd_v),
        .ru    (rd_u),
        .rk    (rd_k)
    );

    izh_kind_params #(
        .DATA_W (DATA_W)
    ) u_kparams (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (kp_wr),
        .wr_kind   (cfg_addr[2]),
        .wr_field  (kind_field_e'(cfg_addr[1:0])),
        .wr_data   (cfg_data),
        .rd_kind   (kp_sel),
        .rd_vreset (kp_vreset),
        .rd_kick   (kp_kick),
        .rd_slope  (kp_slope),
        .rd_recip  (kp_recip)
    );

    izh_shiftadd_mul #(
        .DATA_W (DATA_W)
    ) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .start (mul_start),
        .op_a  (mul_a),
        .op_b  (mul_b),
        .busy  (mul_busy),
        .done  (mul_done),
        .prod  (mul_prod)
    );

    // ---------------- assertions ----------------
    logic             spk_seen;
    logic [IDX_W-1:0] spk_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            spk_seen <= 1'b0;
            spk_last <= '0;
        end else if (state == ST_IDLE && start) begin
            spk_seen <= 1'b0;
        end else if (spike_valid) begin
            spk_seen <= 1'b1;
            spk_last <= spike_idx;
        end
    end

    a_r10_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (spike_valid && spk_seen) |-> (spike_idx > spk_last));

    a_r10_no_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
        spike_valid |=> !spike_valid);

    a_r7_done_at_last: assert property (@(posedge clk) disable iff (!rst_n)
        step_done |-> (cur_idx == LAST_SLOT));

    a_r2_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cur_idx <= LAST_SLOT);

    a_r4_mul_free: assert property (@(posedge clk) disable iff (!rst_n)
        mul_start |-> !mul_busy);

endmodule

// File: tb/sim_izh_neuron_updater.sv
module sim_izh_neuron_updater;

    localparam int N  = 8;
    localparam int IW = 3;
    localparam longint TH   = 1966080;
    localparam longint CA   = 2621;
    localparam longint CB1  = 393216;
    localparam longint CC   = 9175040;
    localparam longint Q    = 65536;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [IW-1:0] cur_idx;
    logic signed [31:0] cur_in;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_op = 2'd0;
    logic [IW-1:0] cfg_addr = '0;
    logic signed [31:0] cfg_data = '0;
    logic spike_valid;
    logic [IW-1:0] spike_idx;
    logic step_done;

    logic signed [31:0] cur_tab [N];
    assign cur_in = cur_tab[cur_idx];

    always #4 clk = ~clk;

    izh_neuron_updater #(.N_SLOTS(N), .DATA_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start),
        .cur_idx(cur_idx), .cur_in(cur_in),
        .cfg_we(cfg_we), .cfg_op(cfg_op), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
        .spike_valid(spike_valid), .spike_idx(spike_idx), .step_done(step_done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // monotonic event logs sampled away from the active edge
    int spk_total  = 0;
    int done_total = 0;
    int spk_log [1024];
    always @(negedge clk) begin
        if (rst_n && spike_valid) begin
            if (spk_total < 1024) spk_log[spk_total] = int'(spike_idx);
            spk_total++;
        end
        if (rst_n && step_done) done_total++;
    end

    // reference model
    longint mv [N];
    longint mu [N];
    bit     mk [N];
    longint p_vr [2];
    longint p_kk [2];
    longint p_sl [2];
    longint p_rc [2];
    int exp_spk [N];
    int exp_n;

    function automatic longint sat32(input longint x);
        if (x > 64'sd2147483647) return 64'sd2147483647;
        if (x < -64'sd2147483648) return -64'sd2147483648;
        return x;
    endfunction

    function automatic longint mq(input longint x, input longint y);
        return sat32((x * y) >>> 16);
    endfunction

    task automatic model_step();
        exp_n = 0;
        for (int i = 0; i < N; i++) begin
            int k = int'(mk[i]);
            longint v = mv[i];
            longint u = mu[i];
            longint cur = longint'(cur_tab[i]);
            if (v >= TH) begin
                exp_spk[exp_n] = i;
                exp_n++;
                mv[i] = p_vr[k];
                mu[i] = sat32(u + p_kk[k]);
            end else begin
                longint sq = mq(v, v);
                longint vn = sat32(mq(CA, sq) + mq(CB1, v) + CC - u + cur);
                longint d  = sat32(mq(p_sl[k], v) - u);
                mv[i] = vn;
                mu[i] = sat32(u + mq(d, p_rc[k]));
            end
        end
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] op, input logic [IW-1:0] addr, input longint data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_op = op; cfg_addr = addr; cfg_data = 32'(data);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic set_slot(input int i, input longint v, input longint u, input bit k, input longint cur);
        cfg_write(2'd1, IW'(i), v);
        cfg_write(2'd2, IW'(i), u);
        cfg_write(2'd3, IW'(i), longint'(k));
        mv[i] = v; mu[i] = u; mk[i] = k;
        cur_tab[i] = 32'(cur);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(input int base, input string req);
        int guard = 0;
        while (done_total == base && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 20000, {req, " step timeout"}, guard, 20000);
    endtask

    task automatic compare_spikes(input int sbase, input string req);
        int got = spk_total - sbase;
        chk(got == exp_n, {req, " spike count"}, got, exp_n);
        for (int j = 0; j < exp_n && j < got; j++)
            chk(spk_log[sbase + j] == exp_spk[j], {req, " spike index"},
                spk_log[sbase + j], exp_spk[j]);
    endtask

    task automatic run_step(input string req);
        int sbase = spk_total;
        int dbase = done_total;
        model_step();
        pulse_start();
        wait_done(dbase, req);
        repeat (2) @(negedge clk);
        chk(done_total - dbase == 1, {req, " one done pulse"}, done_total - dbase, 1);
        compare_spikes(sbase, req);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(spike_valid == 1'b0, "R1 spike_valid after reset", spike_valid, 0);
        chk(step_done == 1'b0, "R1 step_done after reset", step_done, 0);
        chk(cur_idx == '0, "R1 cur_idx after reset", cur_idx, 0);
    endtask

    task automatic t_threshold();
        for (int i = 0; i < N; i++) set_slot(i, -65 * Q, -13 * Q, bit'(i % 2), 0);
        set_slot(2, TH, -13 * Q, 1'b0, 0);
        set_slot(3, TH - 1, -13 * Q, 1'b1, 0);
        set_slot(5, TH, 2 * Q, 1'b1, 0);
        set_slot(7, TH + 5 * Q, 0, 1'b1, 0);
        run_step("R3 threshold");
        run_step("R3 after reset potential");
    endtask

    task automatic t_dynamics();
        for (int i = 0; i < N; i++)
            set_slot(i, (-70 + 13 * i) * Q + i * 1234, (-14 + 2 * i) * Q,
                     bit'(i % 2), (4 + 3 * i) * Q);
        for (int s = 0; s < 12; s++) run_step("R4 R5 R9 R10 R2 dynamics");
    endtask

    task automatic t_saturation();
        for (int i = 0; i < N; i++) set_slot(i, -65 * Q, -13 * Q, bit'(i % 2), 2 * Q);
        set_slot(1, -20000 * Q, 0, 1'b1, 0);
        set_slot(4, -60 * Q, 0, 1'b0, 64'sd2147418112);
        set_slot(6, -40 * Q, 64'sd2147483647, 1'b0, 0);
        set_slot(0, -30000 * Q, -64'sd2147483648, 1'b0, -64'sd2147483648);
        for (int s = 0; s < 3; s++) run_step("R6 saturation");
    endtask

    task automatic t_busy_ignored();
        int sbase, dbase;
        for (int i = 0; i < N; i++) set_slot(i, -65 * Q, -13 * Q, bit'(i % 2), 0);
        set_slot(6, TH, 0, 1'b0, 0);
        sbase = spk_total;
        dbase = done_total;
        model_step();
        pulse_start();
        repeat (40) @(negedge clk);
        cfg_write(2'd1, IW'(0), TH + Q);        // slot V write mid-step
        cfg_write(2'd0, 3'b001, 30 * Q);       // excitatory kick mid-step
        cfg_write(2'd0, 3'b000, 20 * Q);       // excitatory reset mid-step
        pulse_start();
        wait_done(dbase, "R7");
        repeat (400) @(negedge clk);
        chk(done_total - dbase == 1, "R7 extra start ignored", done_total - dbase, 1);
        chk(step_done == 1'b0, "R7 no new step without start", step_done, 0);
        compare_spikes(sbase, "R7 R8 mid-step");
        run_step("R8 mid-step writes ignored");
        run_step("R8 mid-step writes ignored later");
    endtask

    task automatic t_kind_params();
        cfg_write(2'd0, 3'b000, -50 * Q); p_vr[0] = -50 * Q;
        cfg_write(2'd0, 3'b001, 40 * Q);  p_kk[0] = 40 * Q;
        cfg_write(2'd0, 3'b110, 32768);   p_sl[1] = 32768;
        cfg_write(2'd0, 3'b111, 6554);    p_rc[1] = 6554;
        for (int i = 0; i < N; i++)
            set_slot(i, (i % 3 == 0) ? TH : (-60 + 4 * i) * Q, (-5 + i) * Q,
                     bit'((i / 2) % 2), (6 + 2 * i) * Q);
        for (int s = 0; s < 6; s++) run_step("R8 R9 kind constants");
    endtask

    // ---------------- main ----------------
    initial begin
        p_vr[0] = -65 * Q; p_kk[0] = 10 * Q; p_sl[0] = 15729; p_rc[0] = 1524;
        p_vr[1] = -65 * Q; p_kk[1] = Q;      p_sl[1] = 16384; p_rc[1] = 655;
        for (int i = 0; i < N; i++) cur_tab[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_threshold();
        t_dynamics();
        t_saturation();
        t_busy_ignored();
        t_kind_params();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule